// File: doc/BRIEF.md
# Divided Multi-Phase Loop Clock Generator

This block derives the timing for a sampled phase-correction loop from the fast global clock. A free-running counter divides the global clock by a power-of-two ratio (512 by default). The count is decoded into six output clocks, all at the divided rate, with different phases and duty cycles. Each of the two cascaded switched-capacitor gain stages receives a complementary pair: a reset (input sampling) clock and an amplify (hold) clock. The two clocks of a pair are never high together. The decision latch receives two clocks, where the second is a one-cycle-late copy of the first.

The phases are nested within each divided period. The first stage resets and then amplifies. The second stage samples only while the first holds its amplified result. The latch samples only while the second stage holds its output. Every rising edge of a gain-stage clock follows a dead interval in which both clocks of that pair are low. The charge-pump update of the loop reuses the first stage's amplify clock, so no separate output is needed for it.

Let P be the divide ratio, Q = P/8, and D the dead time (default 2). Each output is registered. After k rising edges since reset release, each output shows the decode of count k mod P.

Top module: `loop_clkgen`

## Requirements
- R1: While rst_ni is low, all six outputs are low. After release, the outputs after k rising edges equal the decode of count k mod P; at count 0 every output is low.
- R2: The whole output pattern repeats every P global cycles (512 by default); consecutive rising edges of stg1_rst_o are exactly P cycles apart.
- R3: stg1_rst_o is high for counts [D, 2Q-D), default [2,126). stg1_amp_o is high for [2Q+D, 6Q-D), default [130,382). The two are never high together.
- R4: stg2_rst_o is high for counts [3Q+D, 5Q-D), default [194,318). stg2_amp_o is high for [5Q+D, 8Q-D), default [322,510). The two are never high together.
- R5: stg2_rst_o is high only while stg1_amp_o is high.
- R6: cmp_early_o is high for counts [6Q+D, 7Q+D), default [386,450), and only while stg2_amp_o is high.
- R7: cmp_late_o equals cmp_early_o delayed by LEAD cycles (default 1), giving a window of [387,451) by default.
- R8: Each rising edge of either clock in a gain-stage pair is preceded by at least D = 2 sampled cycles in which both clocks of that pair are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stg1_rst_o | output | 1 | First gain stage reset/sample clock |
| stg1_amp_o | output | 1 | First gain stage amplify clock, also the pump update |
| stg2_rst_o | output | 1 | Second gain stage reset/sample clock |
| stg2_amp_o | output | 1 | Second gain stage amplify clock |
| cmp_early_o | output | 1 | Decision latch clock, leading copy |
| cmp_late_o | output | 1 | Decision latch clock, delayed copy |

## Verification
Two behaviours are hard to reach from the ports: the period boundary, where the count wraps from P-1 to 0, and an asynchronous reset that arrives in the middle of a period while two nested clocks are high. The stimulus walks boundary counts across two full periods to cover the first. For the second, it drops reset partway through the stage-one amplify phase, checks that every output clears at once, and then checks that the sequence restarts from count 0. Dead time and pair exclusivity are checked on every sampled cycle of the run, including the reset intervals.

// File: rtl/loop_clkgen_pkg.sv
package loop_clkgen_pkg;

  typedef struct packed {
    logic s1_rst;
    logic s1_amp;
    logic s2_rst;
    logic s2_amp;
    logic cmp;
  } phase_req_t;

  function automatic logic in_win(input int c, input int lo, input int hi);
    return (c >= lo) && (c < hi);
  endfunction

endpackage

// File: rtl/lc_div_counter.sv
module lc_div_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  // power-of-two ratio: natural wrap
  assign cnt_nxt_o = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/lc_phase_decode.sv
module lc_phase_decode
  import loop_clkgen_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 512,
  parameter int unsigned DEAD      = 2,
  localparam int unsigned CNT_W    = $clog2(DIV_RATIO)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output phase_req_t       req_o
);
  localparam int Q  = int'(DIV_RATIO / 8);
  localparam int D  = int'(DEAD);

  localparam int S1R_LO = D;         localparam int S1R_HI = 2*Q - D;
  localparam int S1A_LO = 2*Q + D;   localparam int S1A_HI = 6*Q - D;
  localparam int S2R_LO = 3*Q + D;   localparam int S2R_HI = 5*Q - D;
  localparam int S2A_LO = 5*Q + D;   localparam int S2A_HI = 8*Q - D;
  localparam int CMP_LO = 6*Q + D;   localparam int CMP_HI = 7*Q + D;

  int c;
  always_comb begin
    c             = int'(cnt_i);
    req_o.s1_rst  = in_win(c, S1R_LO, S1R_HI);
    req_o.s1_amp  = in_win(c, S1A_LO, S1A_HI);
    req_o.s2_rst  = in_win(c, S2R_LO, S2R_HI);
    req_o.s2_amp  = in_win(c, S2A_LO, S2A_HI);
    req_o.cmp     = in_win(c, CMP_LO, CMP_HI);
  end
endmodule

// File: rtl/lc_pair_separator.sv
module lc_pair_separator (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_a_i,
  input  logic req_b_i,
  output logic clk_a_o,
  output logic clk_b_o
);
  // cross-gated set/reset pair: a side only rises while the other is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_a_o <= 1'b0;
      clk_b_o <= 1'b0;
    end else begin
      clk_a_o <= req_a_i & ~clk_b_o & ~req_b_i;
      clk_b_o <= req_b_i & ~clk_a_o & ~req_a_i;
    end
  end
endmodule

// File: rtl/lc_cmp_delay.sv
module lc_cmp_delay #(
  parameter int unsigned LEAD = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic early_o,
  output logic late_o
);
  logic [LEAD:0] tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q[0] <= 1'b0;
    else         tap_q[0] <= req_i;
  end

  for (genvar i = 1; i <= LEAD; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[i] <= 1'b0;
      else         tap_q[i] <= tap_q[i-1];
    end
  end

  assign early_o = tap_q[0];
  assign late_o  = tap_q[LEAD];
endmodule

// File: rtl/loop_clkgen.sv
module loop_clkgen
  import loop_clkgen_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 512,
  parameter int unsigned DEAD      = 2,
  parameter int unsigned LEAD      = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stg1_rst_o,
  output logic stg1_amp_o,
  output logic stg2_rst_o,
  output logic stg2_amp_o,
  output logic cmp_early_o,
  output logic cmp_late_o
);
  localparam int unsigned CNT_W = $clog2(DIV_RATIO);

  logic [CNT_W-1:0] cnt_nxt;
  phase_req_t       req;

  lc_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_o (cnt_nxt)
  );

  // decode next count so registered outputs line up with the count
  lc_phase_decode #(.DIV_RATIO(DIV_RATIO), .DEAD(DEAD)) u_dec (
    .cnt_i (cnt_nxt),
    .req_o (req)
  );

  lc_pair_separator u_sep1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_a_i (req.s1_rst),
    .req_b_i (req.s1_amp),
    .clk_a_o (stg1_rst_o),
    .clk_b_o (stg1_amp_o)
  );

  lc_pair_separator u_sep2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_a_i (req.s2_rst),
    .req_b_i (req.s2_amp),
    .clk_a_o (stg2_rst_o),
    .clk_b_o (stg2_amp_o)
  );

  lc_cmp_delay #(.LEAD(LEAD)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req.cmp),
    .early_o (cmp_early_o),
    .late_o  (cmp_late_o)
  );
endmodule

// File: rtl/loop_clkgen_chk.sv
module loop_clkgen_chk #(
  parameter int unsigned DIV_RATIO = 512
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stg1_rst_o,
  input logic stg1_amp_o,
  input logic stg2_rst_o,
  input logic stg2_amp_o,
  input logic cmp_early_o,
  input logic cmp_late_o
);
  localparam int unsigned GW = $clog2(DIV_RATIO) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          s1r_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '0;
      seen_q     <= 1'b0;
      s1r_prev_q <= 1'b0;
    end else begin
      s1r_prev_q <= stg1_rst_o;
      if (stg1_rst_o && !s1r_prev_q) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assert_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg1_rst_o && !s1r_prev_q && seen_q) |-> (gap_q == GW'(DIV_RATIO - 1)));

  always @(negedge clk_i) begin
    if (!rst_ni)
      assert_reset_low_R1: assert ({stg1_rst_o, stg1_amp_o, stg2_rst_o,
                                    stg2_amp_o, cmp_early_o, cmp_late_o} == 6'b0);
  end

  assert_excl_s1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stg1_rst_o && stg1_amp_o));

  assert_excl_s2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stg2_rst_o && stg2_amp_o));

  assert_nested_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg2_rst_o |-> stg1_amp_o);

  assert_cmp_inside_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_early_o |-> stg2_amp_o);

  assert_late_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_late_o == $past(cmp_early_o));

  assert_dead_s1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stg1_rst_o) || $rose(stg1_amp_o)) |->
      ($past(!stg1_rst_o && !stg1_amp_o, 1) && $past(!stg1_rst_o && !stg1_amp_o, 2)));

  assert_dead_s2_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stg2_rst_o) || $rose(stg2_amp_o)) |->
      ($past(!stg2_rst_o && !stg2_amp_o, 1) && $past(!stg2_rst_o && !stg2_amp_o, 2)));
endmodule

bind loop_clkgen loop_clkgen_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (.*);

// File: tb/loop_clkgen_tb_top.sv
`timescale 1ns/1ps
module loop_clkgen_tb_top;
  localparam int unsigned P = 512;
  localparam int NV = 20;

  // {count[8:0], s1_rst, s1_amp, s2_rst, s2_amp, cmp_early, cmp_late}
  localparam logic [14:0] VEC [NV] = '{
    {9'd1,   6'b000000}, {9'd2,   6'b100000}, {9'd125, 6'b100000},
    {9'd126, 6'b000000}, {9'd129, 6'b000000}, {9'd130, 6'b010000},
    {9'd194, 6'b011000}, {9'd317, 6'b011000}, {9'd318, 6'b010000},
    {9'd322, 6'b010100}, {9'd381, 6'b010100}, {9'd382, 6'b000100},
    {9'd386, 6'b000110}, {9'd387, 6'b000111}, {9'd449, 6'b000111},
    {9'd450, 6'b000101}, {9'd451, 6'b000100}, {9'd509, 6'b000100},
    {9'd510, 6'b000000}, {9'd511, 6'b000000}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic s1r, s1a, s2r, s2a, ce, cl;

  int n_cmp = 0;
  int n_bad = 0;
  int cur   = 0;
  bit done  = 1'b0;

  int run1 = 0, run2 = 0;
  int dead_bad = 0, excl_bad = 0, late_bad = 0;
  logic p_s1r = 0, p_s1a = 0, p_s2r = 0, p_s2a = 0, p_ce = 0;
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  loop_clkgen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .stg1_rst_o  (s1r),
    .stg1_amp_o  (s1a),
    .stg2_rst_o  (s2r),
    .stg2_amp_o  (s2a),
    .cmp_early_o (ce),
    .cmp_late_o  (cl)
  );

  function automatic logic [5:0] outs();
    return {s1r, s1a, s2r, s2a, ce, cl};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // walk to absolute count since release, sample mid-cycle
  task automatic go_to(input int tgt);
    repeat (tgt - cur) @(posedge clk);
    cur = tgt;
    @(negedge clk);
  endtask

  // continuous monitor for R3 R4 R7 R8, sampled at negedges
  always @(negedge clk) begin
    if (mon_on) begin
      if ((s1r && !p_s1r) || (s1a && !p_s1a)) if (run1 < 2) dead_bad++;
      if ((s2r && !p_s2r) || (s2a && !p_s2a)) if (run2 < 2) dead_bad++;
      if ((s1r && s1a) || (s2r && s2a)) excl_bad++;
      if (rst_ni && cl !== p_ce) late_bad++;
      run1 = (!s1r && !s1a) ? run1 + 1 : 0;
      run2 = (!s2r && !s2a) ? run2 + 1 : 0;
      p_s1r = s1r; p_s1a = s1a; p_s2r = s2r; p_s2a = s2a; p_ce = ce;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs low in reset", outs(), 6'b0);
    mon_on = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    cur = 0;

    // two full periods: boundaries and wrap (R1 R2 R3 R4 R5 R6 R7)
    for (int per = 0; per < 2; per++) begin
      for (int i = 0; i < NV; i++) begin
        go_to(per * P + int'(VEC[i][14:6]));
        chk(per == 0 ? "R3 R4 R5 R6 R7 phase pattern" : "R2 pattern after wrap",
            outs(), VEC[i][5:0]);
      end
    end
    go_to(2 * P);
    chk("R2 count wraps to zero, all low", outs(), 6'b0);
    go_to(2 * P + 2);
    chk("R2 stage-one reset repeats after P", outs(), 6'b100000);

    // mid-period async reset while nested clocks are high
    go_to(2 * P + 200);
    chk("R5 nested phase before reset", outs(), 6'b011000);
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 async clear mid-period", outs(), 6'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    cur = 0;
    go_to(1);
    chk("R1 restart count 1", outs(), 6'b000000);
    go_to(2);
    chk("R1 restart count 2", outs(), 6'b100000);
    go_to(130);
    chk("R3 amplify after restart", outs(), 6'b010000);

    chk("R8 dead time violations", dead_bad, 0);
    chk("R3 R4 pair exclusivity violations", excl_bad, 0);
    chk("R7 late copy violations", late_bad, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule